// File: doc/BRIEF.md
# DMA Control, Mask and Request Unit

This block is the control-port section of a four-channel DMA controller. It decodes byte writes and reads on the upper half of a sixteen-entry port window (offsets 8 to 15). It holds a command byte, one mode byte per channel, a four-bit channel mask, a byte-order flip-flop and an eight-bit status byte. The upper status nibble holds one request bit per channel. The lower nibble holds one terminal-count bit per channel. Offsets 0 to 7 belong to the address and count section, which sits outside this block; this unit ignores writes to them.

Peripherals raise and drop their request bits through hold and release inputs. The transfer engine reports terminal counts through a pulse input. The channel-register section toggles the byte flip-flop through a toggle input. Each cycle the block presents a registered service vector. It names every channel that is unmasked and has its request bit set, with no priority between channels.

Top module: `dma_ctl_unit`

## Requirements
- R1: A write to offset 8 loads the command byte only if the value has no bit other than bit 2 set (mask 0xFB clear). Any other value leaves the command byte unchanged.
- R2: A write to offset 9 takes the channel from data bits [1:0]. It sets request bit 4+channel of status when data bit 2 is 1, and clears it when bit 2 is 0. In both cases it clears terminal-count bit channel.
- R3: A write to offset 10 sets mask bit data[1:0] when data bit 2 is 1, and clears that bit when data bit 2 is 0. The other mask bits are unchanged.
- R4: A write to offset 11 stores the whole data byte as the mode of channel data[1:0]. The mode_out port shows the mode of the channel chosen by mode_sel.
- R5: A write to offset 12 clears the byte flip-flop. Otherwise byte_toggle inverts it. A clear wins over a toggle in the same cycle.
- R6: A write to offset 13 sets the mask to all ones and clears status, command and the flip-flop. It leaves the mode bytes unchanged, and it overrides every other input in that cycle.
- R7: A write to offset 14 clears all mask bits. A write to offset 15 loads the mask from data bits [3:0].
- R8: With rd_en high, rd_data is combinational. Offset 8 returns the status byte (requests in [7:4], terminal counts in [3:0]) and clears the terminal-count nibble at the clock edge. Offset 15 returns {4'b0, mask}. Every other offset, and rd_en low, gives 0.
- R9: hold_req[i] sets request bit 4+i and release_req[i] clears it. Release wins over hold, and an offset 9 write to the same channel wins over both.
- R10: tc_pulse[i] sets terminal-count bit i. It wins over a status-read clear and an offset 9 clear in the same cycle, but not over offset 13.
- R11: service[i] equals (not mask[i]) and (request bit 4+i), taken from the state one clock earlier.
- R12: After reset the mask is 1111 and status, command, modes, flip-flop and service are all 0.
- R13: Writes to offsets 0 to 7 change no state of this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed offset |
| rd_en | input | 1 | Read strobe for the addressed offset |
| offset | input | 4 | Port offset within the controller window |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte (combinational) |
| hold_req | input | 4 | Per-channel request raise |
| release_req | input | 4 | Per-channel request drop |
| tc_pulse | input | 4 | Per-channel terminal-count report |
| byte_toggle | input | 1 | Flip-flop toggle from the channel-register section |
| mode_sel | input | 2 | Channel whose mode appears on mode_out |
| mode_out | output | 8 | Mode byte of the selected channel |
| cmd_out | output | 8 | Command byte |
| mask_out | output | 4 | Channel mask |
| status_out | output | 8 | Status byte |
| ff_out | output | 1 | Byte flip-flop |
| service | output | 4 | Channels granted service, registered |

## Verification
The service vector is driven with random mixes of mask writes and hold/release traffic. These patterns separate the registered one-cycle lag from a combinational grant, and they show that every qualified channel is granted with no priority order. Directed cycles place competing sources on one bit: a release against an offset 9 set, a terminal-count pulse against a status read, and a toggle against a flip-flop clear. These expose a wrong ordering of the sources. Command values with single stray bits separate the legal-value filter from a plain load. Writes to offsets 0 to 7 and a master reset with modes already loaded show which state each operation must leave alone.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_LEGAL_MASK = 8'h04;

  typedef struct packed {
    logic cmd;
    logic req;
    logic smask;
    logic mode;
    logic ffclr;
    logic mrst;
    logic mclr;
    logic mall;
  } ctl_wr_t;

  // A command is legal when nothing outside the permitted bit is set.
  function automatic logic cmd_is_legal(input logic [BYTE_W-1:0] v);
    return (v & ~CMD_LEGAL_MASK) == '0;
  endfunction

  // Next flip-flop value from clear and toggle events.
  function automatic logic ff_next(input logic cur, input logic clr, input logic tog);
    if (clr) return 1'b0;
    if (tog) return ~cur;
    return cur;
  endfunction

endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
#(
  parameter int unsigned OFS_W = 4
) (
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] offset,
  output ctl_wr_t          wr_stb,
  output logic             rd_status,
  output logic             rd_mask
);
  localparam int unsigned SEL_W = OFS_W - 1;

  logic             in_ctl;
  logic [SEL_W-1:0] sel;

  assign in_ctl = offset[OFS_W-1];
  assign sel    = offset[SEL_W-1:0];

  always_comb begin
    wr_stb = '0;
    if (wr_en && in_ctl) begin
      case (sel)
        3'd0: wr_stb.cmd   = 1'b1;
        3'd1: wr_stb.req   = 1'b1;
        3'd2: wr_stb.smask = 1'b1;
        3'd3: wr_stb.mode  = 1'b1;
        3'd4: wr_stb.ffclr = 1'b1;
        3'd5: wr_stb.mrst  = 1'b1;
        3'd6: wr_stb.mclr  = 1'b1;
        default: wr_stb.mall = 1'b1;
      endcase
    end
  end

  assign rd_status = rd_en && in_ctl && (sel == 3'd0);
  assign rd_mask   = rd_en && in_ctl && (sel == 3'd7);

endmodule

// File: rtl/dma_mask_reg.sv
module dma_mask_reg #(
  parameter int unsigned NCH = 4,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_all,
  input  logic           clr_all,
  input  logic           load_all,
  input  logic           single,
  input  logic [NCH-1:0] data_lo,
  output logic [NCH-1:0] mask_q
);
  logic [CH_W-1:0] ch;
  logic            flag;

  assign ch   = data_lo[CH_W-1:0];
  assign flag = data_lo[CH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '1;
    else if (set_all)  mask_q <= '1;
    else if (clr_all)  mask_q <= '0;
    else if (load_all) mask_q <= data_lo;
    else if (single)   mask_q[ch] <= flag;
  end

endmodule

// File: rtl/dma_status_reg.sv
module dma_status_reg #(
  parameter int unsigned NCH = 4,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_wr,
  input  logic            wipe,
  input  logic            rd_clear,
  input  logic [CH_W:0]   wr_sel,
  input  logic [NCH-1:0]  hold_req,
  input  logic [NCH-1:0]  release_req,
  input  logic [NCH-1:0]  tc_pulse,
  output logic [NCH-1:0]  req_q,
  output logic [NCH-1:0]  tc_q
);
  logic [NCH-1:0]  req_n, tc_n;
  logic [CH_W-1:0] ch;

  assign ch = wr_sel[CH_W-1:0];

  always_comb begin
    req_n = req_q;
    tc_n  = tc_q;
    for (int i = 0; i < NCH; i++) begin
      if (release_req[i])   req_n[i] = 1'b0;
      else if (hold_req[i]) req_n[i] = 1'b1;
    end
    if (rd_clear) tc_n = '0;
    if (req_wr) begin
      req_n[ch] = wr_sel[CH_W];
      tc_n[ch]  = 1'b0;
    end
    tc_n = tc_n | tc_pulse;
    if (wipe) begin
      req_n = '0;
      tc_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      tc_q  <= '0;
    end else begin
      req_q <= req_n;
      tc_q  <= tc_n;
    end
  end

endmodule

// File: rtl/dma_mode_bank.sv
module dma_mode_bank #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned DW   = 8,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_wr,
  input  logic [DW-1:0]   wr_data,
  input  logic [CH_W-1:0] mode_sel,
  output logic [DW-1:0]   mode_out
);
  logic [DW-1:0] mode_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic hit;
    assign hit = mode_wr && (wr_data[CH_W-1:0] == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mode_q[g] <= '0;
      else if (hit) mode_q[g] <= wr_data;
    end
  end

  assign mode_out = mode_q[mode_sel];

endmodule

// File: rtl/dma_ctl_unit.sv
module dma_ctl_unit
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned DW    = 8,
  parameter int unsigned OFS_W = 4,
  localparam int unsigned CH_W = $clog2(NCH),
  localparam int unsigned ST_W = 2 * NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] offset,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [NCH-1:0]   hold_req,
  input  logic [NCH-1:0]   release_req,
  input  logic [NCH-1:0]   tc_pulse,
  input  logic             byte_toggle,
  input  logic [CH_W-1:0]  mode_sel,
  output logic [DW-1:0]    mode_out,
  output logic [DW-1:0]    cmd_out,
  output logic [NCH-1:0]   mask_out,
  output logic [ST_W-1:0]  status_out,
  output logic             ff_out,
  output logic [NCH-1:0]   service
);
  ctl_wr_t        wr_stb;
  logic           rd_status, rd_mask;
  logic [NCH-1:0] req_q, tc_q;
  logic [NCH-1:0] grant_d;
  logic           cmd_accept;
  logic           cmd_reject;

  dma_ctl_decode #(.OFS_W(OFS_W)) u_dec (
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .offset   (offset),
    .wr_stb   (wr_stb),
    .rd_status(rd_status),
    .rd_mask  (rd_mask)
  );

  dma_mask_reg #(.NCH(NCH)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_all (wr_stb.mrst),
    .clr_all (wr_stb.mclr),
    .load_all(wr_stb.mall),
    .single  (wr_stb.smask),
    .data_lo (wr_data[NCH-1:0]),
    .mask_q  (mask_out)
  );

  dma_status_reg #(.NCH(NCH)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_wr     (wr_stb.req),
    .wipe       (wr_stb.mrst),
    .rd_clear   (rd_status),
    .wr_sel     (wr_data[CH_W:0]),
    .hold_req   (hold_req),
    .release_req(release_req),
    .tc_pulse   (tc_pulse),
    .req_q      (req_q),
    .tc_q       (tc_q)
  );

  dma_mode_bank #(.NCH(NCH), .DW(DW)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_wr (wr_stb.mode),
    .wr_data (wr_data),
    .mode_sel(mode_sel),
    .mode_out(mode_out)
  );

  assign cmd_accept = wr_stb.cmd && cmd_is_legal(wr_data);
  assign cmd_reject = wr_stb.cmd && !cmd_is_legal(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cmd_out <= '0;
    else if (wr_stb.mrst) cmd_out <= '0;
    else if (cmd_accept)  cmd_out <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_out <= 1'b0;
    else        ff_out <= ff_next(ff_out, wr_stb.ffclr | wr_stb.mrst, byte_toggle);
  end

  assign grant_d = ~mask_out & req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) service <= '0;
    else        service <= grant_d;
  end

  assign status_out = {req_q, tc_q};

  always_comb begin
    rd_data = '0;
    if (rd_status)    rd_data = DW'(status_out);
    else if (rd_mask) rd_data = DW'(mask_out);
  end

endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned DW    = 8,
  parameter int unsigned OFS_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic [OFS_W-1:0]   offset,
  input logic [DW-1:0]      wr_data,
  input logic [DW-1:0]      rd_data,
  input logic [NCH-1:0]     tc_pulse,
  input logic [DW-1:0]      cmd_out,
  input logic [NCH-1:0]     mask_out,
  input logic [2*NCH-1:0]   status_out,
  input logic               ff_out,
  input logic [NCH-1:0]     service,
  input logic               cmd_reject
);
  logic wr_mrst, wr_mclr, rd_stat;
  assign wr_mrst = wr_en && (offset == OFS_W'(13));
  assign wr_mclr = wr_en && (offset == OFS_W'(14));
  assign rd_stat = rd_en && (offset == OFS_W'(8));

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> $stable(cmd_out)); // R1

  AST_MRST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mrst |=> (mask_out == '1) && (status_out == '0) && (cmd_out == '0) && !ff_out); // R6

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> (mask_out == '0)); // R7

  AST_TC_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && (tc_pulse == '0)) |=> (status_out[NCH-1:0] == '0)); // R8

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0)); // R8

  AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((tc_pulse != '0) && !wr_mrst) |=> ((status_out[NCH-1:0] & $past(tc_pulse)) == $past(tc_pulse))); // R10

  AST_SVC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (service == ($past(~mask_out) & $past(status_out[2*NCH-1:NCH])))); // R11

endmodule

bind dma_ctl_unit dma_ctl_chk #(.NCH(NCH), .DW(DW), .OFS_W(OFS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .offset    (offset),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .tc_pulse  (tc_pulse),
  .cmd_out   (cmd_out),
  .mask_out  (mask_out),
  .status_out(status_out),
  .ff_out    (ff_out),
  .service   (service),
  .cmd_reject(cmd_reject)
);

// File: tb/test_dma_ctl_unit.sv
module test_dma_ctl_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, byte_toggle = 1'b0;
  logic [3:0] offset = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] hold_req = '0, release_req = '0, tc_pulse = '0;
  logic [1:0] mode_sel = '0;
  logic [7:0] rd_data, mode_out, cmd_out, status_out;
  logic [3:0] mask_out, service;
  logic       ff_out;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [3:0] m_mask, m_req, m_tc, m_svc;
  logic [7:0] m_cmd;
  logic       m_ff;
  logic [7:0] m_mode [4];

  always #5 clk = ~clk;

  dma_ctl_unit i_dma_ctl_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .offset(offset),
    .wr_data(wr_data), .rd_data(rd_data), .hold_req(hold_req),
    .release_req(release_req), .tc_pulse(tc_pulse), .byte_toggle(byte_toggle),
    .mode_sel(mode_sel), .mode_out(mode_out), .cmd_out(cmd_out),
    .mask_out(mask_out), .status_out(status_out), .ff_out(ff_out),
    .service(service)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic r, input logic [3:0] o);
    if (r && o == 4'd8)  return {m_req, m_tc};
    if (r && o == 4'd15) return {4'h0, m_mask};
    return 8'h00;
  endfunction

  task automatic model_reset();
    m_mask = 4'hF; m_req = '0; m_tc = '0; m_svc = '0; m_cmd = '0; m_ff = 1'b0;
    for (int i = 0; i < 4; i++) m_mode[i] = '0;
  endtask

  task automatic model_step();
    logic w13;
    w13 = wr_en && offset == 4'd13;
    m_svc = ~m_mask & m_req;
    if (wr_en) begin
      if (offset == 4'd13) m_mask = 4'hF;
      else if (offset == 4'd14) m_mask = 4'h0;
      else if (offset == 4'd15) m_mask = wr_data[3:0];
      else if (offset == 4'd10) m_mask[wr_data[1:0]] = wr_data[2];
    end
    for (int i = 0; i < 4; i++) begin
      if (release_req[i]) m_req[i] = 1'b0;
      else if (hold_req[i]) m_req[i] = 1'b1;
    end
    if (rd_en && offset == 4'd8) m_tc = '0;
    if (wr_en && offset == 4'd9) begin
      m_req[wr_data[1:0]] = wr_data[2];
      m_tc[wr_data[1:0]]  = 1'b0;
    end
    m_tc = m_tc | tc_pulse;
    if (w13) begin m_req = '0; m_tc = '0; m_cmd = '0; end
    if (wr_en && offset == 4'd8 && (wr_data & 8'hFB) == 8'h00) m_cmd = wr_data;
    if (wr_en && (offset == 4'd12 || w13)) m_ff = 1'b0;
    else if (byte_toggle) m_ff = ~m_ff;
    if (wr_en && offset == 4'd11) m_mode[wr_data[1:0]] = wr_data;
  endtask

  // One clock: drive at negedge, check the read path, clock, check state.
  task automatic cyc(input logic w, input logic r, input logic [3:0] o, input logic [7:0] d,
                     input logic [3:0] h, input logic [3:0] rl, input logic [3:0] t,
                     input logic tg, input logic [1:0] ms);
    @(negedge clk);
    wr_en = w; rd_en = r; offset = o; wr_data = d; hold_req = h;
    release_req = rl; tc_pulse = t; byte_toggle = tg; mode_sel = ms;
    #1;
    check("R8 rd_data", rd_data, exp_read(r, o));
    @(posedge clk);
    model_step();
    #1;
    check("R3/R7 mask", {4'h0, mask_out}, {4'h0, m_mask});
    check("R2/R9/R10 status", status_out, {m_req, m_tc});
    check("R1 cmd", cmd_out, m_cmd);
    check("R5 ff", {7'h0, ff_out}, {7'h0, m_ff});
    check("R4 mode", mode_out, m_mode[ms]);
    check("R11 service", {4'h0, service}, {4'h0, m_svc});
    wr_en = 0; rd_en = 0; hold_req = 0; release_req = 0; tc_pulse = 0; byte_toggle = 0;
  endtask

  task automatic wr(input logic [3:0] o, input logic [7:0] d);
    cyc(1'b1, 1'b0, o, d, 4'h0, 4'h0, 4'h0, 1'b0, 2'd0);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 4'h0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b0, 2'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12 mask", {4'h0, mask_out}, 8'h0F);
    check("R12 status", status_out, 8'h00);
    check("R12 cmd", cmd_out, 8'h00);
    check("R12 service", {4'h0, service}, 8'h00);
    check("R12 ff", {7'h0, ff_out}, 8'h00);
    check("R12 mode", mode_out, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R1 legal and illegal command values
    wr(4'd8, 8'h04); check("R1 accept 04", cmd_out, 8'h04);
    wr(4'd8, 8'h05); check("R1 reject 05", cmd_out, 8'h04);
    wr(4'd8, 8'h80); check("R1 reject 80", cmd_out, 8'h04);
    wr(4'd8, 8'h00); check("R1 accept 00", cmd_out, 8'h00);

    // R4 mode bytes
    wr(4'd11, 8'h66); wr(4'd11, 8'hA1);
    cyc(1'b0, 1'b0, 4'h0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b0, 2'd2);
    check("R4 mode ch2", mode_out, 8'h66);

    // R2 request write and R11 lag, R7 clear all masks
    wr(4'd14, 8'h00);
    wr(4'd9, 8'h07);
    check("R2 req ch3 set", status_out, 8'h80);
    check("R11 service lag", {4'h0, service}, 8'h00);
    idle();
    check("R11 service ch3", {4'h0, service}, 8'h08);

    // R9 offset 9 clear beats hold on the same channel
    cyc(1'b1, 1'b0, 4'd9, 8'h03, 4'h8, 4'h0, 4'h0, 1'b0, 2'd0);
    check("R9 write beats hold", status_out, 8'h00);
    // R9 release beats hold
    cyc(1'b0, 1'b0, 4'd0, 8'h00, 4'h3, 4'h1, 4'h0, 1'b0, 2'd0);
    check("R9 release beats hold", status_out, 8'h20);

    // R10 terminal count beats the status-read clear
    cyc(1'b0, 1'b0, 4'd0, 8'h00, 4'h0, 4'h0, 4'h5, 1'b0, 2'd0);
    cyc(1'b0, 1'b1, 4'd8, 8'h00, 4'h0, 4'h0, 4'h2, 1'b0, 2'd0);
    check("R10 tc survives read", status_out, 8'h22);
    cyc(1'b0, 1'b1, 4'd8, 8'h00, 4'h0, 4'h0, 4'h0, 1'b0, 2'd0);
    check("R8 tc cleared", status_out, 8'h20);

    // R5 clear beats toggle
    cyc(1'b0, 1'b0, 4'd0, 8'h00, 4'h0, 4'h0, 4'h0, 1'b1, 2'd0);
    check("R5 toggle", {7'h0, ff_out}, 8'h01);
    cyc(1'b1, 1'b0, 4'd12, 8'h00, 4'h0, 4'h0, 4'h0, 1'b1, 2'd0);
    check("R5 clear wins", {7'h0, ff_out}, 8'h00);

    // R3 single mask, R7 load all
    wr(4'd15, 8'h0A); check("R7 load all", {4'h0, mask_out}, 8'h0A);
    wr(4'd10, 8'h04); check("R3 set ch0", {4'h0, mask_out}, 8'h0B);
    wr(4'd10, 8'h01); check("R3 clr ch1", {4'h0, mask_out}, 8'h09);

    // R13 low offsets have no effect
    for (int o = 0; o < 8; o++) wr(4'(o), 8'hFF);
    check("R13 mask kept", {4'h0, mask_out}, 8'h09);
    check("R13 status kept", status_out, 8'h20);

    // R6 master reset keeps modes
    cyc(1'b1, 1'b0, 4'd13, 8'h00, 4'hF, 4'h0, 4'hF, 1'b1, 2'd1);
    check("R6 mask", {4'h0, mask_out}, 8'h0F);
    check("R6 status", status_out, 8'h00);
    check("R6 mode kept", mode_out, 8'hA1);

    // Random traffic checked against the model
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] h, rl;
      h  = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      rl = ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'h0;
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0),
          ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'($urandom_range(8, 15)),
          ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 7)) : 8'($urandom),
          h, rl, ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0,
          1'($urandom_range(0, 1)), 2'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule